// File: doc/BRIEF.md
# Orderwire Overhead Serial Drop

The block takes the three overhead bytes that carry the local orderwire, the express orderwire and the maintenance channel. An upstream framer extracts them from each received frame. The block sends each byte on a serial line of its own. All three lines share one slow reference clock that is divided down from the receive byte clock. A frame marker output tells a downstream consumer where the first bit of every byte starts.

The upstream logic presents a byte triple together with a valid strobe whenever it has captured fresh values, and it pulses a frame-start strobe once per frame. The block holds captured bytes in a staging register. On each frame start it loads the staging register into three shifters and restarts the divider phase. It then sends eight bits per line, most significant bit first, one bit per reference period. After the eighth bit it holds the last bit until the next frame begins. The staging register means that a capture arriving mid-frame never disturbs the byte being sent.

Top module: `ow_drop`

## Requirements
- R1: While in reset and directly after it, the three serial lines, the reference clock `ref_clk_o` and the frame marker are all low.
- R2: Between frame starts, `ref_clk_o` is free-running with a period of DIV byte-clock cycles: DIV/2 cycles high, then DIV/2 cycles low.
- R3: In the cycle after `sof_i` is sampled high, `ref_clk_o` is high and a new reference period begins, whatever phase the divider had.
- R4: `frame_o` goes high in the cycle after `sof_i` is sampled and stays high for exactly ROW_CYC cycles. A new `sof_i` restarts that count.
- R5: Each line sends its byte most significant bit first. Bit 7 occupies the first reference period after the frame start and bit 0 the eighth. Each bit lasts DIV cycles, and a line changes only where `ref_clk_o` rises.
- R6: `e1_ser_o` carries the byte from `e1_byte_i`, `e2_ser_o` the byte from `e2_byte_i`, and `f1_ser_o` the byte from `f1_byte_i`, independently of each other.
- R7: After the eighth bit, each line holds bit 0 of its byte until the next `sof_i`.
- R8: Bytes strobed by `byte_vld_i` are sent starting at the next `sof_i`. A strobe during a transmission leaves the bits in flight unchanged.
- R9: When `byte_vld_i` and `sof_i` are sampled in the same cycle, the frame that starts sends the previously staged bytes, and the new bytes go out at the following `sof_i`.
- R10: A `sof_i` that arrives before the eight bits have finished aborts the current byte and restarts at bit 7 of the staged byte.
- R11: With no `byte_vld_i` between two frame starts, the same bytes are sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Frame-start strobe, one cycle |
| byte_vld_i | input | 1 | Capture strobe for the three byte inputs |
| e1_byte_i | input | 8 | Local orderwire byte |
| e2_byte_i | input | 8 | Express orderwire byte |
| f1_byte_i | input | 8 | Maintenance channel byte |
| e1_ser_o | output | 1 | Local orderwire serial line |
| e2_ser_o | output | 1 | Express orderwire serial line |
| f1_ser_o | output | 1 | Maintenance channel serial line |
| ref_clk_o | output | 1 | Shared divided reference clock |
| frame_o | output | 1 | Frame marker, high for ROW_CYC cycles |

## Verification
Two situations are hard to reach from the ports. The first is a capture strobe that lands mid-byte or in the same cycle as the frame start: the staged value must not leak into the bits already in flight. The second is a frame start that arrives before the eighth bit. The stimulus reaches both by driving `byte_vld_i` at a chosen cycle offset inside a checked frame, by asserting `byte_vld_i` together with `sof_i`, and by cutting a frame short after three bit periods before issuing the next `sof_i`. The bench's own staging model predicts which byte each frame must carry.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam int NCH = 3;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {CH_E1 = 2'd0, CH_E2 = 2'd1, CH_F1 = 2'd2} ch_e;
endpackage

// File: rtl/ow_div.sv
module ow_div #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic ref_clk_o,
  output logic tick_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] HALF = W'(DIV / 2);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= HALF;  // start in low phase
    else if (sync_i)          div_q <= '0;
    else if (div_q == LAST)   div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

  assign ref_clk_o = div_q < HALF;
  assign tick_o    = (div_q == LAST) && !sync_i;
endmodule

// File: rtl/ow_frame.sv
module ow_frame #(
  parameter int ROW_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic frame_o
);
  localparam int CW = $clog2(ROW_CYC + 1);
  localparam logic [CW-1:0] ROW = CW'(ROW_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (sync_i)       cnt_q <= ROW;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign frame_o = cnt_q != '0;
endmodule

// File: rtl/ow_ser.sv
module ow_ser
  import ow_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cap_i,
  input  byte_t byte_i,
  input  logic  sync_i,
  input  logic  tick_i,
  output logic  bit_o
);
  byte_t      stg_q, sh_q;
  logic [2:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stg_q <= '0;
    else if (cap_i) stg_q <= byte_i;
  end

  // load old staged value on sync; a same-cycle capture waits one frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= 3'd7;
    end else if (sync_i) begin
      sh_q  <= stg_q;
      idx_q <= 3'd0;
    end else if (tick_i && idx_q != 3'd7) begin
      sh_q  <= {sh_q[6:0], 1'b0};
      idx_q <= idx_q + 3'd1;
    end
  end

  assign bit_o = sh_q[7];
endmodule

// File: rtl/ow_drop.sv
module ow_drop
  import ow_pkg::*;
#(
  parameter int DIV     = 8,
  parameter int ROW_CYC = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sof_i,
  input  logic       byte_vld_i,
  input  logic [7:0] e1_byte_i,
  input  logic [7:0] e2_byte_i,
  input  logic [7:0] f1_byte_i,
  output logic       e1_ser_o,
  output logic       e2_ser_o,
  output logic       f1_ser_o,
  output logic       ref_clk_o,
  output logic       frame_o
);
  logic  tick;
  byte_t bytes [NCH];
  logic  ser   [NCH];

  assign bytes[CH_E1] = e1_byte_i;
  assign bytes[CH_E2] = e2_byte_i;
  assign bytes[CH_F1] = f1_byte_i;

  ow_div #(.DIV(DIV)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sof_i),
    .ref_clk_o (ref_clk_o),
    .tick_o    (tick)
  );

  ow_frame #(.ROW_CYC(ROW_CYC)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sof_i),
    .frame_o (frame_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ow_ser u_ser (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (byte_vld_i),
      .byte_i (bytes[g]),
      .sync_i (sof_i),
      .tick_i (tick),
      .bit_o  (ser[g])
    );
  end

  assign e1_ser_o = ser[CH_E1];
  assign e2_ser_o = ser[CH_E2];
  assign f1_ser_o = ser[CH_F1];
endmodule

// File: rtl/ow_drop_chk.sv
module ow_drop_chk #(
  parameter int DIV     = 8,
  parameter int ROW_CYC = 12
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sof_i,
  input logic e1_ser_o,
  input logic e2_ser_o,
  input logic f1_ser_o,
  input logic ref_clk_o,
  input logic frame_o
);
  localparam int CW = $clog2(ROW_CYC + 1) + 1;
  logic [CW-1:0] hi_q;
  logic [2:0]    lines;

  assign lines = {e1_ser_o, e2_ser_o, f1_ser_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (sof_i)   hi_q <= '0;
    else if (frame_o) hi_q <= hi_q + 1'b1;
    else              hi_q <= '0;
  end

  p_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> ref_clk_o);

  p_frame_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> frame_o);

  p_row_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (hi_q < CW'(ROW_CYC)));

  p_bit_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(sof_i) && !$stable(lines)) |-> $rose(ref_clk_o));
endmodule

bind ow_drop ow_drop_chk #(.DIV(DIV), .ROW_CYC(ROW_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sof_i     (sof_i),
  .e1_ser_o  (e1_ser_o),
  .e2_ser_o  (e2_ser_o),
  .f1_ser_o  (f1_ser_o),
  .ref_clk_o (ref_clk_o),
  .frame_o   (frame_o)
);

// File: tb/sim_ow_drop.sv
`timescale 1ns/1ps
module sim_ow_drop;
  localparam int DIV = 8;
  localparam int ROW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sof = 1'b0, vld = 1'b0;
  logic [7:0] b1 = '0, b2 = '0, b3 = '0;
  logic s1, s2, s3, rck, frm;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m1 = '0, m2 = '0, m3 = '0;  // bench staging model

  always #2.5 clk = ~clk;

  ow_drop #(.DIV(DIV), .ROW_CYC(ROW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_vld_i(vld),
    .e1_byte_i(b1), .e2_byte_i(b2), .f1_byte_i(b3),
    .e1_ser_o(s1), .e2_ser_o(s2), .f1_ser_o(s3),
    .ref_clk_o(rck), .frame_o(frm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic capture(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk); vld = 1'b1; b1 = a; b2 = b; b3 = c;
    @(negedge clk); vld = 1'b0;
    m1 = a; m2 = b; m3 = c;
  endtask

  // ends at the negedge of the first cycle after sof is sampled
  task automatic pulse_sof(input bit with_cap, input logic [7:0] a,
                           input logic [7:0] b, input logic [7:0] c);
    @(negedge clk); sof = 1'b1;
    if (with_cap) begin vld = 1'b1; b1 = a; b2 = b; b3 = c; end
    @(negedge clk); sof = 1'b0; vld = 1'b0;
  endtask

  // walks ncyc cycles of a frame starting at cycle 0 (first after sof)
  task automatic walk(input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] e3,
                      input int ncyc, input int cap_c, input logic [7:0] na,
                      input logic [7:0] nb, input logic [7:0] nc, input string tag);
    int fcnt = 0;
    for (int c = 0; c < ncyc; c++) begin
      if (c == cap_c) begin vld = 1'b1; b1 = na; b2 = nb; b3 = nc; end
      if (c == cap_c + 1) begin vld = 1'b0; m1 = na; m2 = nb; m3 = nc; end
      if (frm) fcnt++;
      if (c == 0) chk(rck == 1'b1, {tag, " R3 ref high after sof"}, rck, 1);
      if (c == DIV / 2) chk(rck == 1'b0, {tag, " R2 ref low half"}, rck, 0);
      if (c % DIV == 1 && c / DIV < 8) begin
        int i = 7 - c / DIV;
        chk(s1 == e1[i], {tag, " R5 R6 e1 bit"}, s1, e1[i]);
        chk(s2 == e2[i], {tag, " R5 R6 e2 bit"}, s2, e2[i]);
        chk(s3 == e3[i], {tag, " R5 R6 f1 bit"}, s3, e3[i]);
      end
      @(negedge clk);
    end
    if (ncyc >= 8 * DIV) chk(fcnt == ROW, {tag, " R4 frame width"}, fcnt, ROW);
  endtask

  task automatic t_reset;
    chk({s1, s2, s3, rck, frm} == 5'b0, "R1 in reset", {s1, s2, s3, rck, frm}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk({s1, s2, s3, frm} == 4'b0, "R1 after reset", {s1, s2, s3, frm}, 0);
  endtask

  task automatic t_freerun;
    int hi = 0, lo = 0;
    while (rck != 1'b1) @(negedge clk);
    while (rck == 1'b1) begin hi++; @(negedge clk); end
    while (rck == 1'b0) begin lo++; @(negedge clk); end
    chk(hi == DIV / 2, "R2 high time", hi, DIV / 2);
    chk(lo == DIV / 2, "R2 low time", lo, DIV / 2);
  endtask

  task automatic t_basic;
    capture(8'hA5, 8'h3C, 8'hF0);
    repeat (3) @(negedge clk);
    pulse_sof(1'b0, '0, '0, '0);
    walk(8'hA5, 8'h3C, 8'hF0, 8 * DIV, -5, '0, '0, '0, "basic");
    repeat (2 * DIV) @(negedge clk);
    chk(s1 == 1'b1 && s2 == 1'b0 && s3 == 1'b0, "R7 lsb hold", {s1, s2, s3}, 3'b100);
  endtask

  task automatic t_mid_cap;
    logic [7:0] o1 = m1, o2 = m2, o3 = m3;
    capture(8'h81, 8'h7E, 8'h55);
    pulse_sof(1'b0, '0, '0, '0);
    walk(8'h81, 8'h7E, 8'h55, 8 * DIV, 3 * DIV + 2, 8'h12, 8'hC3, 8'h99, "midcap R8");
    pulse_sof(1'b0, '0, '0, '0);
    walk(8'h12, 8'hC3, 8'h99, 8 * DIV, -5, '0, '0, '0, "nextframe R8");
    chk(o1 != 8'h12 || o2 != 8'hC3, "R8 model", 0, 0);
  endtask

  task automatic t_same_cycle;
    logic [7:0] o1 = m1, o2 = m2, o3 = m3;
    pulse_sof(1'b1, 8'h0F, 8'hE1, 8'h66);
    m1 = 8'h0F; m2 = 8'hE1; m3 = 8'h66;
    walk(o1, o2, o3, 8 * DIV, -5, '0, '0, '0, "samecyc R9 old");
    pulse_sof(1'b0, '0, '0, '0);
    walk(8'h0F, 8'hE1, 8'h66, 8 * DIV, -5, '0, '0, '0, "samecyc R9 new");
  endtask

  task automatic t_abort;
    capture(8'hFF, 8'h00, 8'hAA);
    pulse_sof(1'b0, '0, '0, '0);
    walk(8'hFF, 8'h00, 8'hAA, 3 * DIV + 3, -5, '0, '0, '0, "abort part");
    capture(8'h4B, 8'hB4, 8'h2D);
    pulse_sof(1'b0, '0, '0, '0);
    walk(8'h4B, 8'hB4, 8'h2D, 8 * DIV, -5, '0, '0, '0, "abort R10 restart");
  endtask

  task automatic t_resend;
    pulse_sof(1'b0, '0, '0, '0);
    walk(m1, m2, m3, 8 * DIV, -5, '0, '0, '0, "resend R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_freerun;
    t_basic;
    t_mid_cap;
    t_same_cycle;
    t_abort;
    t_resend;
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule